// File: doc/BRIEF.md
# One-Shot Fault Suppression Controller

This block holds four one-shot suppression bits. Each bit hides one class of fault from the fault logic for exactly one instruction, or for one mandatory register-stack memory reference. Each bit then clears itself when the matching completion event occurs. The four classes are instruction debug, instruction access-bit, data access/dirty-bit and data debug. Software sets the bits through the saved status copy, and a return-from-interruption loads them. The fault logic then samples the per-class mask outputs while it evaluates a fault of that class.

The clearing rules differ by bit. A successfully completed instruction clears all four bits. A fault-free register-stack reference clears only the two data bits. Entry into the legacy instruction set strips the three native-only bits, whether that entry is a branch or a return-from-interruption that resumes in legacy mode. Fault detection itself lives outside this block.

Top module: `fsup_ctrl`

## Requirements
- R1: Reset clears all four bits, and all four mask outputs read 0 while the bits are 0. Bit order everywhere is bit 0 instruction debug, bit 1 instruction access, bit 2 data access/dirty, bit 3 data debug.
- R2: A cycle with `rfi_load`=1 and `legacy_mode`=0 makes `sup_bits` equal `rfi_bits` on the next cycle.
- R3: A cycle with `rfi_load`=1 and `legacy_mode`=1 loads bit 0 from `rfi_bits` and forces bits 3..1 to 0.
- R4: When `rfi_load` coincides with an instruction completion, a register-stack completion or `to_legacy`, the loaded value wins.
- R5: `insn_done`=1 with `evt_fault`=0 and no load clears all four bits on the next cycle, in either mode.
- R6: `rse_done`=1 with `evt_fault`=0, with no instruction completion, no load and no legacy entry, clears bits 3 and 2 and leaves bits 1 and 0 unchanged.
- R7: A cycle with `evt_fault`=1 leaves all four bits unchanged when there is no load and no legacy entry. This holds even if `insn_done` or `rse_done` is set.
- R8: `to_legacy`=1 without a load clears bits 3..1 on the next cycle. Bit 0 is kept unless a successful instruction completes in the same cycle.
- R9: `sup_mask[k]` equals `sup_bits[k] & chk_class[k]` in the same cycle. Mask bits 3..1 are held at 0 while `legacy_mode`=1.
- R10: With no strobe active, the bits hold their value. The `legacy_mode` level alone changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | An instruction completed this cycle |
| rse_done | input | 1 | A mandatory register-stack reference completed this cycle |
| evt_fault | input | 1 | The completing instruction or reference raised a fault |
| legacy_mode | input | 1 | The instruction stream is in the legacy instruction set |
| to_legacy | input | 1 | Branch into legacy mode taken this cycle |
| rfi_load | input | 1 | Return-from-interruption: load the saved bits |
| rfi_bits | input | 4 | Saved suppression bits for the load |
| chk_class | input | 4 | Fault classes being evaluated this cycle |
| sup_bits | output | 4 | Live suppression bits |
| sup_mask | output | 4 | Per-class fault mask |

## Verification
The bench builds the block with `LEGACY_EN` at 1, its default. With that value, the legacy-entry stripping, the legacy-mode load path and the legacy mask gating can all be reached. A single stimulus table carries the state from one step to the next. This lets it pair loads with completions, faults with both completion kinds, and entries with kept bits. Directed steps then cover the mask gating, the mode level on its own, and a reset in the middle of a run.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int unsigned NCLS   = 4;
  localparam int unsigned B_IDBG = 0;
  localparam int unsigned B_IACC = 1;
  localparam int unsigned B_DACC = 2;
  localparam int unsigned B_DDBG = 3;

  typedef logic [NCLS-1:0] cls_vec_t;

  // bits released by a fault-free instruction
  function automatic cls_vec_t insn_clear();
    cls_vec_t v;
    v = '1;
    return v;
  endfunction

  // bits released by a fault-free register-stack reference
  function automatic cls_vec_t rse_clear();
    cls_vec_t v;
    v = '0;
    v[B_DACC] = 1'b1;
    v[B_DDBG] = 1'b1;
    return v;
  endfunction

  // bits that only apply to native instructions
  function automatic cls_vec_t native_only();
    cls_vec_t v;
    v = '0;
    v[B_IACC] = 1'b1;
    v[B_DACC] = 1'b1;
    v[B_DDBG] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fsup_event_decode.sv
module fsup_event_decode
  import fsup_pkg::*;
#(
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic     insn_done,
  input  logic     rse_done,
  input  logic     evt_fault,
  input  logic     legacy_mode,
  input  logic     to_legacy,
  input  logic     rfi_load,
  input  cls_vec_t rfi_bits,
  output cls_vec_t clr_vec,
  output logic     load_en,
  output cls_vec_t load_val
);
  logic insn_ok;
  logic rse_ok;
  logic leg_entry;
  logic leg_now;

  assign insn_ok = insn_done & ~evt_fault;
  assign rse_ok  = rse_done & ~evt_fault;

  generate
    if (LEGACY_EN) begin : g_leg
      assign leg_entry = to_legacy;
      assign leg_now   = legacy_mode;
    end else begin : g_noleg
      assign leg_entry = 1'b0;
      assign leg_now   = 1'b0;
    end
  endgenerate

  always_comb begin
    clr_vec = '0;
    if (insn_ok)   clr_vec = clr_vec | insn_clear();
    if (rse_ok)    clr_vec = clr_vec | rse_clear();
    if (leg_entry) clr_vec = clr_vec | native_only();
  end

  assign load_en  = rfi_load;
  assign load_val = leg_now ? (rfi_bits & ~native_only()) : rfi_bits;
endmodule

// File: rtl/fsup_state_reg.sv
module fsup_state_reg
  import fsup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  cls_vec_t load_val,
  input  cls_vec_t clr_vec,
  output cls_vec_t bits_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       bits_q <= '0;
    else if (load_en) bits_q <= load_val;
    else              bits_q <= bits_q & ~clr_vec;
  end
endmodule

// File: rtl/fsup_mask_gate.sv
module fsup_mask_gate
  import fsup_pkg::*;
#(
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cls_vec_t bits_i,
  input  cls_vec_t chk_i,
  input  logic     legacy_i,
  output cls_vec_t mask_o
);
  localparam cls_vec_t NATIVE = native_only();

  generate
    for (genvar k = 0; k < NCLS; k++) begin : g_cls
      if (LEGACY_EN && NATIVE[k]) begin : g_nat
        assign mask_o[k] = bits_i[k] & chk_i[k] & ~legacy_i;
      end else begin : g_any
        assign mask_o[k] = bits_i[k] & chk_i[k];
      end
    end
  endgenerate

  AST_MASK_INSIDE_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~chk_i) == '0);  // R9
  AST_MASK_INSIDE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~bits_i) == '0);  // R9
  if (LEGACY_EN) begin : g_leg_ast
    AST_MASK_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_i |-> (mask_o & NATIVE) == '0);  // R9
  end
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
#(
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_done,
  input  logic       rse_done,
  input  logic       evt_fault,
  input  logic       legacy_mode,
  input  logic       to_legacy,
  input  logic       rfi_load,
  input  logic [3:0] rfi_bits,
  input  logic [3:0] chk_class,
  output logic [3:0] sup_bits,
  output logic [3:0] sup_mask
);
  cls_vec_t clr_vec;
  cls_vec_t load_val;
  logic     load_en;
  cls_vec_t bits_q;

  fsup_event_decode #(.LEGACY_EN(LEGACY_EN)) u_dec (
    .insn_done(insn_done), .rse_done(rse_done), .evt_fault(evt_fault),
    .legacy_mode(legacy_mode), .to_legacy(to_legacy), .rfi_load(rfi_load),
    .rfi_bits(rfi_bits), .clr_vec(clr_vec), .load_en(load_en),
    .load_val(load_val));

  fsup_state_reg u_st (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .clr_vec(clr_vec), .bits_q(bits_q));

  fsup_mask_gate #(.LEGACY_EN(LEGACY_EN)) u_msk (
    .clk(clk), .rst_n(rst_n), .bits_i(bits_q), .chk_i(chk_class),
    .legacy_i(legacy_mode), .mask_o(sup_mask));

  assign sup_bits = bits_q;

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sup_bits == '0);  // R1
  AST_RFI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_load |=> sup_bits[B_IDBG] == $past(rfi_bits[B_IDBG]));  // R4
  AST_INSN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && !evt_fault && !rfi_load |=> sup_bits == '0);  // R5
  AST_RSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rse_done && !evt_fault && !insn_done && !rfi_load && !to_legacy
    |=> sup_bits[3:2] == 2'b00 && sup_bits[1:0] == $past(sup_bits[1:0]));  // R6
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault && !rfi_load && !to_legacy |=> $stable(sup_bits));  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_done && !rse_done && !rfi_load && !to_legacy |=> $stable(sup_bits));  // R10

  generate
    if (LEGACY_EN) begin : g_leg_ast
      AST_RFI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_load && !legacy_mode |=> sup_bits == $past(rfi_bits));  // R2
      AST_LEGACY_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_load && legacy_mode |=> sup_bits[3:1] == 3'b000);  // R3
      AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        to_legacy && !rfi_load |=> sup_bits[3:1] == 3'b000);  // R8
    end else begin : g_noleg_ast
      AST_RFI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_load |=> sup_bits == $past(rfi_bits));  // R2
    end
  endgenerate
endmodule

// File: tb/sim_fsup_ctrl.sv
`timescale 1ns/1ps
module sim_fsup_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 1'b0, rse_done = 1'b0, evt_fault = 1'b0;
  logic legacy_mode = 1'b0, to_legacy = 1'b0, rfi_load = 1'b0;
  logic [3:0] rfi_bits = '0, chk_class = '0;
  logic [3:0] sup_bits, sup_mask;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fsup_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rse_done(rse_done),
    .evt_fault(evt_fault), .legacy_mode(legacy_mode), .to_legacy(to_legacy),
    .rfi_load(rfi_load), .rfi_bits(rfi_bits), .chk_class(chk_class),
    .sup_bits(sup_bits), .sup_mask(sup_mask));

  // {rfi, rfi_bits[3:0], insn_done, rse_done, fault, to_legacy, legacy, expected[3:0]}
  localparam int NV = 17;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111},  // R2
    {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111},  // R10
    {1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0011},  // R6
    {1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0011},  // R7
    {1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},  // R5
    {1'b1, 4'b1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1010},  // R2
    {1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1010},  // R7
    {1'b1, 4'b0111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111},  // R4
    {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},  // R8
    {1'b1, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001},  // R3
    {1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000},  // R5
    {1'b1, 4'b1101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1101},  // R2
    {1'b1, 4'b1100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1100},  // R4
    {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000},  // R8
    {1'b1, 4'b1110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1110},  // R4
    {1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1110},  // R7
    {1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0010}   // R6
  };
  localparam int TAG [NV] = '{2, 10, 6, 7, 5, 2, 7, 4, 8, 3, 5, 2, 4, 8, 4, 7, 6};

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    insn_done = 1'b0; rse_done = 1'b0; evt_fault = 1'b0;
    to_legacy = 1'b0; rfi_load = 1'b0; rfi_bits = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset bits", sup_bits, 4'b0000);
    chk_class = 4'b1111;
    #1;
    check("R1 reset mask", sup_mask, 4'b0000);
    chk_class = '0;
    rst_n = 1'b1;
    @(posedge clk); #5;

    for (int i = 0; i < NV; i++) begin
      rfi_load    = VEC[i][13];
      rfi_bits    = VEC[i][12:9];
      insn_done   = VEC[i][8];
      rse_done    = VEC[i][7];
      evt_fault   = VEC[i][6];
      to_legacy   = VEC[i][5];
      legacy_mode = VEC[i][4];
      @(posedge clk); #5;
      clear_strobes();
      legacy_mode = 1'b0;
      check($sformatf("R%0d vector %0d", TAG[i], i), sup_bits, VEC[i][3:0]);
    end

    // R9: mask gating by class
    rfi_load = 1'b1; rfi_bits = 4'b1111;
    @(posedge clk); #5;
    clear_strobes();
    chk_class = 4'b0101;
    #1;
    check("R9 mask by class", sup_mask, 4'b0101);
    chk_class = 4'b0000;
    #1;
    check("R9 mask idle", sup_mask, 4'b0000);
    // R9 / R10: mode level alone gates masks, keeps bits
    legacy_mode = 1'b1; chk_class = 4'b1111;
    #1;
    check("R9 legacy mask", sup_mask, 4'b0001);
    @(posedge clk); #5;
    check("R10 mode level keeps bits", sup_bits, 4'b1111);
    legacy_mode = 1'b0;
    #1;
    check("R9 native mask", sup_mask, 4'b1111);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(posedge clk); #5;
    check("R1 mid-run reset", sup_bits, 4'b0000);
    rst_n = 1'b1; chk_class = '0;
    @(posedge clk); #5;
    finish_run();
  end
endmodule